// File: doc/BRIEF.md
# Instruction Line Fetch Requester

This block sits in a multithreaded fetch stage and supplies whole instruction cache lines. Each thread owns a one-line buffer: the line data, the line's aligned address and a valid bit. The fetch stage presents a thread number and a program counter. The block clears the offset bits of the counter and compares the result with that thread's buffered line. A match is reported as a hit in the same cycle. A mismatch launches a line read on a ready/valid memory request port.

Only one miss per thread may be in flight. Each request carries a per-thread sequence tag, so the block can recognise and discard responses that belong to squashed or superseded requests. If the memory port refuses a read, the read is parked in a single retry slot shared by all threads. While the slot holds a read, every new fetch is refused. A retry pulse from memory resends the parked read. A squash on a thread abandons its miss and frees the retry slot if that thread owns it. Snoop probes carry no state change and are only acknowledged.

Top module: `ilf_line_fetch`

## Requirements
- R1: Every address sent on the request port has its low log2(LINE_BYTES) bits (6 bits by default) at zero. Hit comparison uses the program counter with those bits cleared.
- R2: An eligible fetch whose thread buffer is valid and whose aligned address equals the buffered address raises `fetch_hit_o` in the same cycle and issues no request.
- R3: An eligible fetch that misses drives a request in the same cycle. The request carries the fetch thread, the aligned address and a tag one above that thread's previous tag (the first tag after reset is 1, modulo 2^TAG_W). On the next cycle the thread's buffer address holds the new aligned address and its valid bit is 0.
- R4: A missing fetch refused by the port (`mem_req_ready_i` low) puts the thread in wait-for-retry (state code 1) and sets `cache_blocked_o`. An accepted miss puts the thread in wait-for-response (code 2).
- R5: A fetch is refused (no hit, no request) in any of these cases: `cache_blocked_o` is set; `irq_pend_i` is high and `fetch_phys_i` is low; its thread is being squashed; or its thread is not in the running (code 0) or access-complete (code 3) state.
- R6: `mem_retry_i` with the retry slot occupied resends the parked thread, address and tag. If the port accepts it, the owner moves to wait-for-response and `cache_blocked_o` clears. `mem_retry_i` with the slot empty only clears `cache_blocked_o`.
- R7: A response is accepted only when its thread is in wait-for-response, its tag equals that thread's latest tag, and that thread is not squashed in the same cycle. Every other response leaves the buffers unchanged and adds one to `drop_cnt_o`.
- R8: An accepted response stores the line data and sets the valid bit. The thread moves to blocked (code 4) if its `stall_i` bit is high, and to access-complete (code 3) otherwise.
- R9: A squash returns the thread to running (code 0) on the next cycle. If the thread owns the retry slot, the slot empties and `cache_blocked_o` clears.
- R10: An access-complete thread returns to running after a fetch attempt that hits. A blocked thread returns to running on the first cycle its `stall_i` bit is low.
- R11: `snoop_ack_o` is high exactly one cycle after `snoop_valid_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req_i | input | 1 | Fetch attempt this cycle |
| fetch_tid_i | input | TID_W | Thread of the fetch attempt |
| fetch_pc_i | input | ADDR_W | Program counter to fetch |
| fetch_phys_i | input | 1 | Physical-mode access, allowed while an interrupt is pending |
| irq_pend_i | input | 1 | Interrupt pending |
| stall_i | input | NUM_THR | Per-thread downstream stall |
| squash_i | input | NUM_THR | Per-thread squash |
| fetch_hit_o | output | 1 | Buffered line satisfies the fetch |
| mem_req_valid_o | output | 1 | Line read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_tid_o | output | TID_W | Request thread |
| mem_req_addr_o | output | ADDR_W | Aligned line address |
| mem_req_tag_o | output | TAG_W | Request sequence tag |
| mem_retry_i | input | 1 | Memory can take a refused request now |
| mem_rsp_valid_i | input | 1 | Line response valid |
| mem_rsp_tid_i | input | TID_W | Response thread |
| mem_rsp_tag_i | input | TAG_W | Response sequence tag |
| mem_rsp_data_i | input | 8*LINE_BYTES | Response line data |
| snoop_valid_i | input | 1 | Snoop probe |
| snoop_ack_o | output | 1 | Snoop acknowledge |
| rd_tid_i | input | TID_W | Thread whose buffer is shown |
| rd_valid_o | output | 1 | Selected buffer valid bit |
| rd_addr_o | output | ADDR_W | Selected buffer line address |
| rd_data_o | output | 8*LINE_BYTES | Selected buffer line data |
| thr_state_o | output | 3*NUM_THR | Per-thread state codes: 0 run, 1 wait-retry, 2 wait-response, 3 complete, 4 blocked |
| cache_blocked_o | output | 1 | Retry slot occupied, new fetches refused |
| drop_cnt_o | output | CNT_W | Count of discarded responses |

## Verification
The checker watches five things on every cycle: request addresses are line aligned, a hit never coincides with a request, refusals hold under the blocked flag and under an interrupt, a port refusal always sets the blocked flag, and the discard counter moves by at most one and only with a response. Several behaviours need the bench's cycle-accurate reference model, driven through random and directed traffic: matching response tags against each thread's history, whether a stalled or clear thread lands in blocked or complete, the identity of the parked request when it is resent, and the release of the slot when its owner is squashed.

// File: rtl/ilf_pkg.sv
package ilf_pkg;

   typedef enum logic [2:0] {
      TS_RUN        = 3'd0,
      TS_WAIT_RETRY = 3'd1,
      TS_WAIT_RSP   = 3'd2,
      TS_DONE       = 3'd3,
      TS_BLOCKED    = 3'd4
   } thr_state_e;

   localparam int unsigned STATE_W = 3;

endpackage

// File: rtl/ilf_thread_ctx.sv
module ilf_thread_ctx
   import ilf_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 512,
   parameter int TAG_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              squash_i,
   input  logic              stall_i,
   input  logic              rsp_take_i,
   input  logic [DATA_W-1:0] rsp_data_i,
   input  logic              resend_ok_i,
   input  logic              miss_i,
   input  logic              miss_sent_i,
   input  logic [ADDR_W-1:0] miss_addr_i,
   input  logic              hit_i,
   output thr_state_e        state_o,
   output logic              line_valid_o,
   output logic [ADDR_W-1:0] line_addr_o,
   output logic [DATA_W-1:0] line_data_o,
   output logic [TAG_W-1:0]  seq_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_o      <= TS_RUN;
         line_valid_o <= 1'b0;
         line_addr_o  <= '0;
         line_data_o  <= '0;
         seq_o        <= '0;
      end else if (squash_i) begin
         state_o <= TS_RUN;
      end else if (rsp_take_i) begin
         line_data_o  <= rsp_data_i;
         line_valid_o <= 1'b1;
         state_o      <= stall_i ? TS_BLOCKED : TS_DONE;
      end else if (resend_ok_i) begin
         state_o <= TS_WAIT_RSP;
      end else if (miss_i) begin
         line_addr_o  <= miss_addr_i;
         line_valid_o <= 1'b0;
         seq_o        <= seq_o + TAG_W'(1);
         state_o      <= miss_sent_i ? TS_WAIT_RSP : TS_WAIT_RETRY;
      end else if (hit_i) begin
         state_o <= TS_RUN;
      end else if (state_o == TS_BLOCKED && !stall_i) begin
         state_o <= TS_RUN;
      end
   end

endmodule

// File: rtl/ilf_retry_slot.sv
module ilf_retry_slot #(
   parameter int TID_W  = 1,
   parameter int ADDR_W = 32,
   parameter int TAG_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [TID_W-1:0]  load_tid_i,
   input  logic [ADDR_W-1:0] load_addr_i,
   input  logic [TAG_W-1:0]  load_tag_i,
   input  logic              release_i,
   input  logic              retry_empty_i,
   output logic              full_o,
   output logic [TID_W-1:0]  tid_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [TAG_W-1:0]  tag_o,
   output logic              blocked_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_o    <= 1'b0;
         tid_o     <= '0;
         addr_o    <= '0;
         tag_o     <= '0;
         blocked_o <= 1'b0;
      end else if (load_i) begin
         full_o    <= 1'b1;
         tid_o     <= load_tid_i;
         addr_o    <= load_addr_i;
         tag_o     <= load_tag_i;
         blocked_o <= 1'b1;
      end else if (release_i) begin
         full_o    <= 1'b0;
         blocked_o <= 1'b0;
      end else if (retry_empty_i) begin
         blocked_o <= 1'b0;
      end
   end

endmodule

// File: rtl/ilf_line_fetch.sv
module ilf_line_fetch
   import ilf_pkg::*;
#(
   parameter int NUM_THR       = 2,
   parameter int ADDR_W        = 32,
   parameter int LINE_BYTES    = 64,
   parameter int TAG_W         = 4,
   parameter int CNT_W         = 16,
   parameter int SNOOP_ACK_LAT = 1,
   localparam int TID_W  = $clog2(NUM_THR),
   localparam int DATA_W = LINE_BYTES * 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fetch_req_i,
   input  logic [TID_W-1:0]         fetch_tid_i,
   input  logic [ADDR_W-1:0]        fetch_pc_i,
   input  logic                     fetch_phys_i,
   input  logic                     irq_pend_i,
   input  logic [NUM_THR-1:0]       stall_i,
   input  logic [NUM_THR-1:0]       squash_i,
   output logic                     fetch_hit_o,
   output logic                     mem_req_valid_o,
   input  logic                     mem_req_ready_i,
   output logic [TID_W-1:0]         mem_req_tid_o,
   output logic [ADDR_W-1:0]        mem_req_addr_o,
   output logic [TAG_W-1:0]         mem_req_tag_o,
   input  logic                     mem_retry_i,
   input  logic                     mem_rsp_valid_i,
   input  logic [TID_W-1:0]         mem_rsp_tid_i,
   input  logic [TAG_W-1:0]         mem_rsp_tag_i,
   input  logic [DATA_W-1:0]        mem_rsp_data_i,
   input  logic                     snoop_valid_i,
   output logic                     snoop_ack_o,
   input  logic [TID_W-1:0]         rd_tid_i,
   output logic                     rd_valid_o,
   output logic [ADDR_W-1:0]        rd_addr_o,
   output logic [DATA_W-1:0]        rd_data_o,
   output logic [STATE_W*NUM_THR-1:0] thr_state_o,
   output logic                     cache_blocked_o,
   output logic [CNT_W-1:0]         drop_cnt_o
);

   localparam int OFS_W = $clog2(LINE_BYTES);

   // Elaboration-time parameter checks
   if (NUM_THR < 2 || (NUM_THR & (NUM_THR - 1)) != 0) begin : g_bad_thr
      $error("NUM_THR must be a power of two of at least 2");
   end
   if (LINE_BYTES < 4 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 4");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr
      $error("ADDR_W must exceed the line offset width");
   end
   if (TAG_W < 2) begin : g_bad_tag
      $error("TAG_W must be at least 2");
   end
   if (SNOOP_ACK_LAT > 1 || SNOOP_ACK_LAT < 0) begin : g_bad_snoop
      $error("SNOOP_ACK_LAT must be 0 or 1");
   end

   // Per-thread context views
   thr_state_e         st   [NUM_THR];
   logic               lv   [NUM_THR];
   logic [ADDR_W-1:0]  la   [NUM_THR];
   logic [DATA_W-1:0]  ld   [NUM_THR];
   logic [TAG_W-1:0]   sq   [NUM_THR];

   // Retry slot view
   logic               slot_full;
   logic [TID_W-1:0]   slot_tid;
   logic [ADDR_W-1:0]  slot_addr;
   logic [TAG_W-1:0]   slot_tag;
   logic               slot_blocked;

   // Fetch decision
   logic [ADDR_W-1:0]  pc_line;
   thr_state_e         cur_st;
   logic               eligible;
   logic               look_hit;
   logic               look_miss;
   logic               resend;
   logic [TAG_W-1:0]   next_tag;
   logic               rsp_ok;
   logic               slot_release;

   assign pc_line  = {fetch_pc_i[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
   assign cur_st   = st[fetch_tid_i];
   assign next_tag = sq[fetch_tid_i] + TAG_W'(1);

   assign eligible = fetch_req_i
                   && !slot_blocked
                   && !(irq_pend_i && !fetch_phys_i)
                   && !squash_i[fetch_tid_i]
                   && (cur_st == TS_RUN || cur_st == TS_DONE);

   assign look_hit  = eligible && lv[fetch_tid_i] && (la[fetch_tid_i] == pc_line);
   assign look_miss = eligible && !look_hit;

   assign resend = mem_retry_i && slot_full && !squash_i[slot_tid];

   assign fetch_hit_o     = look_hit;
   assign mem_req_valid_o = resend || look_miss;
   assign mem_req_tid_o   = resend ? slot_tid  : fetch_tid_i;
   assign mem_req_addr_o  = resend ? slot_addr : pc_line;
   assign mem_req_tag_o   = resend ? slot_tag  : next_tag;

   assign rsp_ok = mem_rsp_valid_i
                && (st[mem_rsp_tid_i] == TS_WAIT_RSP)
                && (mem_rsp_tag_i == sq[mem_rsp_tid_i])
                && !squash_i[mem_rsp_tid_i];

   assign slot_release = (slot_full && squash_i[slot_tid])
                      || (resend && mem_req_ready_i);

   for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
      logic sel_fetch;
      logic sel_rsp;
      logic sel_slot;

      assign sel_fetch = (fetch_tid_i == TID_W'(t));
      assign sel_rsp   = (mem_rsp_tid_i == TID_W'(t));
      assign sel_slot  = (slot_tid == TID_W'(t));

      ilf_thread_ctx #(
         .ADDR_W (ADDR_W),
         .DATA_W (DATA_W),
         .TAG_W  (TAG_W)
      ) u_ctx (
         .clk          (clk),
         .rst_n        (rst_n),
         .squash_i     (squash_i[t]),
         .stall_i      (stall_i[t]),
         .rsp_take_i   (rsp_ok && sel_rsp),
         .rsp_data_i   (mem_rsp_data_i),
         .resend_ok_i  (resend && mem_req_ready_i && sel_slot),
         .miss_i       (look_miss && sel_fetch),
         .miss_sent_i  (mem_req_ready_i),
         .miss_addr_i  (pc_line),
         .hit_i        (look_hit && sel_fetch),
         .state_o      (st[t]),
         .line_valid_o (lv[t]),
         .line_addr_o  (la[t]),
         .line_data_o  (ld[t]),
         .seq_o        (sq[t])
      );

      assign thr_state_o[t*STATE_W +: STATE_W] = st[t];
   end

   ilf_retry_slot #(
      .TID_W  (TID_W),
      .ADDR_W (ADDR_W),
      .TAG_W  (TAG_W)
   ) u_slot (
      .clk           (clk),
      .rst_n         (rst_n),
      .load_i        (look_miss && !mem_req_ready_i),
      .load_tid_i    (fetch_tid_i),
      .load_addr_i   (pc_line),
      .load_tag_i    (next_tag),
      .release_i     (slot_release),
      .retry_empty_i (mem_retry_i && !slot_full),
      .full_o        (slot_full),
      .tid_o         (slot_tid),
      .addr_o        (slot_addr),
      .tag_o         (slot_tag),
      .blocked_o     (slot_blocked)
   );

   assign cache_blocked_o = slot_blocked;

   // Discarded-response counter
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         drop_cnt_o <= '0;
      end else if (mem_rsp_valid_i && !rsp_ok) begin
         drop_cnt_o <= drop_cnt_o + CNT_W'(1);
      end
   end

   // Snoop acknowledge, combinational or registered
   if (SNOOP_ACK_LAT == 0) begin : g_snoop_comb
      assign snoop_ack_o = snoop_valid_i;
   end else begin : g_snoop_reg
      always_ff @(posedge clk) begin
         if (!rst_n) snoop_ack_o <= 1'b0;
         else        snoop_ack_o <= snoop_valid_i;
      end
   end

   // Buffer readout
   assign rd_valid_o = lv[rd_tid_i];
   assign rd_addr_o  = la[rd_tid_i];
   assign rd_data_o  = ld[rd_tid_i];

endmodule

// File: rtl/ilf_line_fetch_chk.sv
module ilf_line_fetch_chk #(
   parameter int ADDR_W        = 32,
   parameter int OFS_W         = 6,
   parameter int CNT_W         = 16,
   parameter int SNOOP_ACK_LAT = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fetch_phys_i,
   input logic              irq_pend_i,
   input logic              fetch_hit_o,
   input logic              mem_req_valid_o,
   input logic              mem_req_ready_i,
   input logic [ADDR_W-1:0] mem_req_addr_o,
   input logic              mem_rsp_valid_i,
   input logic              snoop_valid_i,
   input logic              snoop_ack_o,
   input logic              cache_blocked_o,
   input logic [CNT_W-1:0]  drop_cnt_o
);

   p_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid_o |-> (mem_req_addr_o[OFS_W-1:0] == '0));

   p_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_hit_o |-> !mem_req_valid_o);

   p_blocked_refuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cache_blocked_o |-> !fetch_hit_o);

   p_irq_refuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend_i && !fetch_phys_i && !cache_blocked_o) |-> (!fetch_hit_o && !mem_req_valid_o));

   p_hold_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid_o && !mem_req_ready_i) |=> cache_blocked_o);

   p_drop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_rsp_valid_i |=> $stable(drop_cnt_o));

   p_drop_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid_i |=> (drop_cnt_o == $past(drop_cnt_o)
                        || drop_cnt_o == $past(drop_cnt_o) + CNT_W'(1)));

   if (SNOOP_ACK_LAT == 1) begin : g_snoop_chk
      p_snoop_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
         snoop_valid_i |=> snoop_ack_o);
   end

endmodule

bind ilf_line_fetch ilf_line_fetch_chk #(
   .ADDR_W        (ADDR_W),
   .OFS_W         ($clog2(LINE_BYTES)),
   .CNT_W         (CNT_W),
   .SNOOP_ACK_LAT (SNOOP_ACK_LAT)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .fetch_phys_i    (fetch_phys_i),
   .irq_pend_i      (irq_pend_i),
   .fetch_hit_o     (fetch_hit_o),
   .mem_req_valid_o (mem_req_valid_o),
   .mem_req_ready_i (mem_req_ready_i),
   .mem_req_addr_o  (mem_req_addr_o),
   .mem_rsp_valid_i (mem_rsp_valid_i),
   .snoop_valid_i   (snoop_valid_i),
   .snoop_ack_o     (snoop_ack_o),
   .cache_blocked_o (cache_blocked_o),
   .drop_cnt_o      (drop_cnt_o)
);

// File: tb/ilf_line_fetch_test.sv
module ilf_line_fetch_test;

   localparam int NT = 2;
   localparam int AW = 32;
   localparam int LB = 64;
   localparam int TW = 4;
   localparam int CW = 16;
   localparam int DW = LB * 8;
   localparam int IW = 1;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n;
   logic          fetch_req_i;
   logic [IW-1:0] fetch_tid_i;
   logic [AW-1:0] fetch_pc_i;
   logic          fetch_phys_i;
   logic          irq_pend_i;
   logic [NT-1:0] stall_i;
   logic [NT-1:0] squash_i;
   logic          fetch_hit_o;
   logic          mem_req_valid_o;
   logic          mem_req_ready_i;
   logic [IW-1:0] mem_req_tid_o;
   logic [AW-1:0] mem_req_addr_o;
   logic [TW-1:0] mem_req_tag_o;
   logic          mem_retry_i;
   logic          mem_rsp_valid_i;
   logic [IW-1:0] mem_rsp_tid_i;
   logic [TW-1:0] mem_rsp_tag_i;
   logic [DW-1:0] mem_rsp_data_i;
   logic          snoop_valid_i;
   logic          snoop_ack_o;
   logic [IW-1:0] rd_tid_i;
   logic          rd_valid_o;
   logic [AW-1:0] rd_addr_o;
   logic [DW-1:0] rd_data_o;
   logic [3*NT-1:0] thr_state_o;
   logic          cache_blocked_o;
   logic [CW-1:0] drop_cnt_o;

   ilf_line_fetch uut (
      .clk(clk), .rst_n(rst_n),
      .fetch_req_i(fetch_req_i), .fetch_tid_i(fetch_tid_i), .fetch_pc_i(fetch_pc_i),
      .fetch_phys_i(fetch_phys_i), .irq_pend_i(irq_pend_i),
      .stall_i(stall_i), .squash_i(squash_i),
      .fetch_hit_o(fetch_hit_o),
      .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
      .mem_req_tid_o(mem_req_tid_o), .mem_req_addr_o(mem_req_addr_o), .mem_req_tag_o(mem_req_tag_o),
      .mem_retry_i(mem_retry_i),
      .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_tid_i(mem_rsp_tid_i),
      .mem_rsp_tag_i(mem_rsp_tag_i), .mem_rsp_data_i(mem_rsp_data_i),
      .snoop_valid_i(snoop_valid_i), .snoop_ack_o(snoop_ack_o),
      .rd_tid_i(rd_tid_i), .rd_valid_o(rd_valid_o), .rd_addr_o(rd_addr_o), .rd_data_o(rd_data_o),
      .thr_state_o(thr_state_o), .cache_blocked_o(cache_blocked_o), .drop_cnt_o(drop_cnt_o)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // Reference model state (codes: 0 run, 1 wait-retry, 2 wait-rsp, 3 complete, 4 blocked)
   int            m_st   [NT];
   bit            m_v    [NT];
   logic [AW-1:0] m_a    [NT];
   logic [DW-1:0] m_d    [NT];
   logic [TW-1:0] m_seq  [NT];
   bit            m_full;
   int            m_stid;
   logic [AW-1:0] m_sa;
   logic [TW-1:0] m_stag;
   bit            m_blk;
   logic [CW-1:0] m_drop;
   bit            m_snoop;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] line_of(input logic [AW-1:0] pc);
      return pc & ~AW'(LB - 1);
   endfunction

   function automatic logic [DW-1:0] rand_line();
      logic [DW-1:0] r;
      for (int i = 0; i < DW / 32; i++) r[i*32 +: 32] = $urandom();
      return r;
   endfunction

   task automatic model_reset();
      for (int t = 0; t < NT; t++) begin
         m_st[t] = 0; m_v[t] = 0; m_a[t] = '0; m_d[t] = '0; m_seq[t] = '0;
      end
      m_full = 0; m_stid = 0; m_sa = '0; m_stag = '0; m_blk = 0; m_drop = '0; m_snoop = 0;
   endtask

   task automatic idle();
      fetch_req_i = 0; fetch_tid_i = '0; fetch_pc_i = '0; fetch_phys_i = 0; irq_pend_i = 0;
      stall_i = '0; squash_i = '0; mem_req_ready_i = 0; mem_retry_i = 0;
      mem_rsp_valid_i = 0; mem_rsp_tid_i = '0; mem_rsp_tag_i = '0; mem_rsp_data_i = '0;
      snoop_valid_i = 0; rd_tid_i = '0;
   endtask

   // Called one time unit after a rising edge with inputs already set.
   task automatic step();
      bit            resend, elig, ehit, emiss, acc, rdy;
      int            ft, rt;
      logic [AW-1:0] al;
      ft  = int'(fetch_tid_i);
      rt  = int'(mem_rsp_tid_i);
      rdy = mem_req_ready_i;
      al  = line_of(fetch_pc_i);
      resend = mem_retry_i && m_full && !squash_i[m_stid];
      elig = fetch_req_i && !m_blk && !(irq_pend_i && !fetch_phys_i) && !squash_i[ft]
             && (m_st[ft] == 0 || m_st[ft] == 3);
      ehit  = elig && m_v[ft] && (m_a[ft] == al);
      emiss = elig && !ehit;
      acc   = mem_rsp_valid_i && m_st[rt] == 2 && mem_rsp_tag_i == m_seq[rt] && !squash_i[rt];
      #1;
      chk(fetch_hit_o == ehit, "R2 R5 hit", 64'(fetch_hit_o), 64'(ehit));
      chk(mem_req_valid_o == (resend || emiss), "R3 R5 R6 req_valid", 64'(mem_req_valid_o), 64'(resend || emiss));
      if (resend) begin
         chk(mem_req_tid_o == IW'(m_stid), "R6 resend tid", 64'(mem_req_tid_o), 64'(m_stid));
         chk(mem_req_addr_o == m_sa, "R6 resend addr", 64'(mem_req_addr_o), 64'(m_sa));
         chk(mem_req_tag_o == m_stag, "R6 resend tag", 64'(mem_req_tag_o), 64'(m_stag));
      end else if (emiss) begin
         chk(mem_req_addr_o == al, "R1 aligned addr", 64'(mem_req_addr_o), 64'(al));
         chk(mem_req_tid_o == fetch_tid_i, "R3 tid", 64'(mem_req_tid_o), 64'(ft));
         chk(mem_req_tag_o == m_seq[ft] + TW'(1), "R3 tag", 64'(mem_req_tag_o), 64'(m_seq[ft] + TW'(1)));
      end
      @(posedge clk);
      // Model update
      if (m_full && squash_i[m_stid]) begin
         m_full = 0; m_blk = 0;
      end else if (resend && rdy) begin
         m_full = 0; m_blk = 0;
      end else if (mem_retry_i && !m_full) begin
         m_blk = 0;
      end
      for (int t = 0; t < NT; t++) begin
         if (squash_i[t]) m_st[t] = 0;
         else if (acc && rt == t) begin
            m_d[t] = mem_rsp_data_i; m_v[t] = 1; m_st[t] = stall_i[t] ? 4 : 3;
         end else if (resend && rdy && m_stid == t) m_st[t] = 2;
         else if (emiss && ft == t) begin
            m_a[t] = al; m_v[t] = 0; m_seq[t] = m_seq[t] + TW'(1); m_st[t] = rdy ? 2 : 1;
         end else if (ehit && ft == t) m_st[t] = 0;
         else if (m_st[t] == 4 && !stall_i[t]) m_st[t] = 0;
      end
      if (emiss && !rdy) begin
         m_full = 1; m_blk = 1; m_stid = ft; m_sa = al; m_stag = m_seq[ft];
      end
      if (mem_rsp_valid_i && !acc) m_drop = m_drop + CW'(1);
      m_snoop = snoop_valid_i;
      #1;
      for (int t = 0; t < NT; t++)
         chk(thr_state_o[t*3 +: 3] == 3'(m_st[t]), "R4 R6 R8 R9 R10 state",
             64'(thr_state_o[t*3 +: 3]), 64'(m_st[t]));
      chk(cache_blocked_o == m_blk, "R4 R6 R9 blocked", 64'(cache_blocked_o), 64'(m_blk));
      chk(drop_cnt_o == m_drop, "R7 drop count", 64'(drop_cnt_o), 64'(m_drop));
      chk(rd_valid_o == m_v[int'(rd_tid_i)], "R3 R8 valid", 64'(rd_valid_o), 64'(m_v[int'(rd_tid_i)]));
      chk(rd_addr_o == m_a[int'(rd_tid_i)], "R3 buffer addr", 64'(rd_addr_o), 64'(m_a[int'(rd_tid_i)]));
      chk(rd_data_o == m_d[int'(rd_tid_i)], "R8 buffer data", rd_data_o[63:0], m_d[int'(rd_tid_i)][63:0]);
      chk(snoop_ack_o == m_snoop, "R11 snoop ack", 64'(snoop_ack_o), 64'(m_snoop));
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog all-requirements actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      idle();
      rst_n = 0;
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      chk(thr_state_o == '0, "R9 reset state", 64'(thr_state_o), 0);
      chk(cache_blocked_o == 0, "R4 reset blocked", 64'(cache_blocked_o), 0);
      chk(drop_cnt_o == '0, "R7 reset count", 64'(drop_cnt_o), 0);
      chk(rd_valid_o == 0, "R8 reset valid", 64'(rd_valid_o), 0);
      rst_n = 1;
      @(posedge clk); #1;

      // R3: miss on thread 0, accepted
      idle(); fetch_req_i = 1; fetch_pc_i = 32'h0000_1234; mem_req_ready_i = 1; step();
      // R8: matching response, no stall -> complete
      idle(); mem_rsp_valid_i = 1; mem_rsp_tag_i = 4'd1; mem_rsp_data_i = rand_line(); step();
      // R2 R10: hit in same line from complete -> run
      idle(); fetch_req_i = 1; fetch_pc_i = 32'h0000_1208; step();
      // R4: thread 1 miss refused by port
      idle(); fetch_req_i = 1; fetch_tid_i = 1; fetch_pc_i = 32'h0000_4010; rd_tid_i = 1; step();
      // R5: thread 0 refused while blocked
      idle(); fetch_req_i = 1; fetch_pc_i = 32'h0000_1200; step();
      // R6: retry with slot occupied, accepted
      idle(); mem_retry_i = 1; mem_req_ready_i = 1; step();
      // R7: stale tag dropped
      idle(); mem_rsp_valid_i = 1; mem_rsp_tid_i = 1; mem_rsp_tag_i = 4'd0; rd_tid_i = 1; step();
      // R8: matching response while stalled -> blocked
      idle(); mem_rsp_valid_i = 1; mem_rsp_tid_i = 1; mem_rsp_tag_i = 4'd1; stall_i = 2'b10;
      mem_rsp_data_i = rand_line(); rd_tid_i = 1; step();
      // R10: stall stays, then releases
      idle(); stall_i = 2'b10; step();
      idle(); step();
      // R5: interrupt refuses non-physical fetch, physical passes (and is refused by port)
      idle(); irq_pend_i = 1; fetch_req_i = 1; fetch_pc_i = 32'h0000_9000; step();
      idle(); irq_pend_i = 1; fetch_req_i = 1; fetch_pc_i = 32'h0000_9000; fetch_phys_i = 1; step();
      // R9: squash of the slot owner clears the block
      idle(); squash_i = 2'b01; snoop_valid_i = 1; step();
      // R6: retry with empty slot
      idle(); mem_retry_i = 1; step();
      // R7: response for a squashed miss
      idle(); fetch_req_i = 1; fetch_pc_i = 32'h0000_7000; mem_req_ready_i = 1; step();
      idle(); squash_i = 2'b01; step();
      idle(); mem_rsp_valid_i = 1; mem_rsp_tag_i = m_seq[0]; step();

      // Constrained random phase
      for (int i = 0; i < 4000; i++) begin
         int rt;
         idle();
         fetch_req_i     = ($urandom() % 10) < 7;
         fetch_tid_i     = IW'($urandom() % NT);
         fetch_pc_i      = AW'((($urandom() % 4) << 6) | ($urandom() % 64) | 32'h0002_0000);
         fetch_phys_i    = $urandom() % 2;
         irq_pend_i      = ($urandom() % 10) == 0;
         for (int t = 0; t < NT; t++) begin
            stall_i[t]  = ($urandom() % 5) == 0;
            squash_i[t] = ($urandom() % 20) == 0;
         end
         mem_req_ready_i = ($urandom() % 10) < 7;
         mem_retry_i     = ($urandom() % 5) == 0;
         mem_rsp_valid_i = ($urandom() % 10) < 3;
         rt              = int'($urandom() % NT);
         mem_rsp_tid_i   = IW'(rt);
         mem_rsp_tag_i   = (($urandom() % 10) < 7) ? m_seq[rt] : TW'($urandom());
         mem_rsp_data_i  = rand_line();
         snoop_valid_i   = ($urandom() % 10) < 3;
         rd_tid_i        = IW'($urandom() % NT);
         step();
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule